// File: doc/BRIEF.md
# Programmable AND Plane with Product-Term Steering

This block is the core of one logic block in a programmable logic device. It takes 36 routed signals and forms each in true and inverted polarity, which gives 72 literal columns. Over those literals it evaluates 86 configurable AND terms. A steering matrix then hands the terms to 16 output cells. Each cell receives a 16-wide bundle that feeds its OR gate. A cell may take anywhere from zero to sixteen terms, and one term may feed any number of cells at once. A term needed by several outputs is therefore built only once.

The configuration is held in registers and loaded through a synchronous write port made of a strobe, an address and a data word. One write replaces a whole AND row or a whole steering row. The path from the routed inputs to the terms and bundles is purely combinational. If a steering write would give one cell more than sixteen terms, the block refuses it and raises an error flag for one cycle.

Top module: `pterm_alloc_core`

## Requirements
- R1: Literal column 2i carries in_sig[i] and column 2i+1 carries its inverse. Each term is the AND of the literals whose connection bits are set in its row.
- R2: A term whose row has no bit set evaluates to 0.
- R3: A write with cfg_addr[7]=0 and cfg_addr[6:0]=t (t<86) replaces the connection row of term t with cfg_wdata[71:0]. Bits 85:72 of the data are ignored. The new row is used from the clock edge that samples the strobe and not before it.
- R4: A write with cfg_addr[7]=1 and cfg_addr[6:0]=c (c<16) replaces the steering row of cell c with cfg_wdata[85:0]. Bit t set means term t is assigned to cell c.
- R5: Slot k of cell c's bundle, at sum_bundle[16c+k], carries the k-th assigned term counted upward from term index 0. Slots past the number of assigned terms are 0.
- R6: One term may be assigned to several cells, and it then appears in each of their bundles.
- R7: A steering write with more than 16 bits set is rejected and leaves all configuration unchanged. cfg_err is 1 in the cycle after that write and 0 otherwise.
- R8: A cell with exactly 16 assigned terms is accepted and fills every slot. A cell with none has a constant-0 bundle.
- R9: A write whose index is out of range (term index of 86 or more, cell index of 16 or more) changes nothing and raises no error.
- R10: Synchronous active-high reset clears every connection and steering bit and clears cfg_err.
- R11: A change on in_sig reaches pt_out and sum_bundle within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| in_sig | input | 36 | Routed input signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Bit 7 selects term rows (0) or steering rows (1); bits 6:0 give the row index |
| cfg_wdata | input | 86 | Row contents to be written |
| cfg_err | output | 1 | Pulses for one cycle after a rejected steering write |
| pt_out | output | 86 | Values of the product terms |
| sum_bundle | output | 256 | Sixteen 16-bit term bundles, one per cell; cell c occupies bits 16c+15:16c |

## Verification
The bench aims at the edges of the allocation count. One steering row has exactly sixteen terms at the low end of the index range and another has sixteen at the high end, and a seventeen-term row must bounce. A design with an off-by-one limit would either refuse the full cell or truncate the oversized one silently. Shared terms and sparse, unordered assignments check slot ordering; a mis-ordered compaction would put the correct values in the wrong slots. Empty rows, out-of-range indices and a check taken before the write edge expose a design that lets erased terms float high, that aliases bad addresses onto real rows, or that applies configuration one cycle early.

// File: rtl/pta_pkg.sv
package pta_pkg;

    parameter int IN_N   = 36;
    parameter int PT_N   = 86;
    parameter int CELL_N = 16;
    parameter int SLOT_N = 16;

    localparam int LIT_N  = 2 * IN_N;
    localparam int DATA_W = (PT_N > LIT_N) ? PT_N : LIT_N;
    localparam int PT_W   = $clog2(PT_N);
    localparam int CELL_W = $clog2(CELL_N);
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int ADDR_W = PT_W + 1;

    typedef enum logic {
        RG_TERM  = 1'b0,
        RG_STEER = 1'b1
    } region_e;

    typedef struct packed {
        logic              we;
        region_e           rg;
        logic [PT_W-1:0]   idx;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    function automatic int ones(input logic [PT_N-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < PT_N; i++)
            if (v[i]) n++;
        return n;
    endfunction

    // Packs selected term values into consecutive slots, lowest term first.
    function automatic logic [SLOT_N-1:0] compact(input logic [PT_N-1:0] sel,
                                                  input logic [PT_N-1:0] val);
        logic [SLOT_N-1:0] res;
        int k;
        res = '0;
        k   = 0;
        for (int t = 0; t < PT_N; t++) begin
            if (sel[t]) begin
                if (k < SLOT_N) res[k[SLOT_W-1:0]] = val[t];
                k++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store
    import pta_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  cfg_wr_t                          wr,
    output logic [PT_N-1:0][LIT_N-1:0]       term_map,
    output logic [CELL_N-1:0][PT_N-1:0]      steer_map,
    output logic                             err
);

    logic term_hit;
    logic steer_in_range;
    logic too_many;
    logic steer_hit;
    int   req_cnt;

    always_comb begin
        req_cnt        = ones(wr.data[PT_N-1:0]);
        too_many       = (req_cnt > SLOT_N);
        term_hit       = wr.we && (wr.rg == RG_TERM) && (int'(wr.idx) < PT_N);
        steer_in_range = wr.we && (wr.rg == RG_STEER) && (int'(wr.idx) < CELL_N);
        steer_hit      = steer_in_range && !too_many;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            term_map  <= '0;
            steer_map <= '0;
            err       <= 1'b0;
        end else begin
            err <= steer_in_range && too_many;
            if (term_hit)
                term_map[wr.idx] <= wr.data[LIT_N-1:0];
            if (steer_hit)
                steer_map[wr.idx[CELL_W-1:0]] <= wr.data[PT_N-1:0];
        end
    end

    // R7: an oversized steering request leaves the whole map as it was
    p_reject_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (steer_in_range && too_many) |=> (steer_map == $past(steer_map)));

    // R7: the flag only follows a steering write
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(wr.we) && $past(wr.rg == RG_STEER)));

    // R3: an accepted term write is visible on the next edge
    p_term_load_r3: assert property (@(posedge clk) disable iff (rst)
        term_hit |=> (term_map[$past(wr.idx)] == $past(wr.data[LIT_N-1:0])));

    generate
        for (genvar g = 0; g < CELL_N; g++) begin : g_cap
            // R8: no stored row ever exceeds the slot count
            p_row_cap_r8: assert property (@(posedge clk) disable iff (rst)
                $countones(steer_map[g]) <= SLOT_N);
        end
    endgenerate

endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane
    import pta_pkg::*;
(
    input  logic [IN_N-1:0]            in_sig,
    input  logic [PT_N-1:0][LIT_N-1:0] term_map,
    output logic [PT_N-1:0]            pt
);

    logic [LIT_N-1:0] lit;

    generate
        for (genvar i = 0; i < IN_N; i++) begin : g_lit
            assign lit[2*i]   = in_sig[i];
            assign lit[2*i+1] = ~in_sig[i];
        end
        for (genvar t = 0; t < PT_N; t++) begin : g_term
            // an erased row yields 0 rather than an empty-AND 1
            assign pt[t] = (|term_map[t]) && (&(lit | ~term_map[t]));
        end
    endgenerate

endmodule

// File: rtl/pta_steer.sv
module pta_steer
    import pta_pkg::*;
(
    input  logic [CELL_N-1:0][PT_N-1:0]   steer_map,
    input  logic [PT_N-1:0]               pt,
    output logic [CELL_N-1:0][SLOT_N-1:0] bundle
);

    generate
        for (genvar c = 0; c < CELL_N; c++) begin : g_cell
            always_comb bundle[c] = compact(steer_map[c], pt);
        end
    endgenerate

endmodule

// File: rtl/pterm_alloc_core.sv
module pterm_alloc_core
    import pta_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IN_N-1:0]          in_sig,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic                     cfg_err,
    output logic [PT_N-1:0]          pt_out,
    output logic [CELL_N*SLOT_N-1:0] sum_bundle
);

    cfg_wr_t                       wr;
    logic [PT_N-1:0][LIT_N-1:0]    term_map;
    logic [CELL_N-1:0][PT_N-1:0]   steer_map;
    logic [CELL_N-1:0][SLOT_N-1:0] bundle;

    always_comb begin
        wr.we   = cfg_we;
        wr.rg   = region_e'(cfg_addr[PT_W]);
        wr.idx  = cfg_addr[PT_W-1:0];
        wr.data = cfg_wdata;
    end

    pta_cfg_store u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .term_map  (term_map),
        .steer_map (steer_map),
        .err       (cfg_err)
    );

    pta_and_plane u_plane (
        .in_sig   (in_sig),
        .term_map (term_map),
        .pt       (pt_out)
    );

    pta_steer u_steer (
        .steer_map (steer_map),
        .pt        (pt_out),
        .bundle    (bundle)
    );

    generate
        for (genvar c = 0; c < CELL_N; c++) begin : g_out
            assign sum_bundle[c*SLOT_N +: SLOT_N] = bundle[c];

            // R8: a cell without terms sees a zero bundle
            p_empty_cell_r8: assert property (@(posedge clk) disable iff (rst)
                (steer_map[c] == '0) |-> (bundle[c] == '0));

            // R5: a bundle never carries more ones than its live assigned terms
            p_bundle_count_r5: assert property (@(posedge clk) disable iff (rst)
                $countones(bundle[c]) <= $countones(steer_map[c] & pt_out));
        end
        for (genvar t = 0; t < PT_N; t++) begin : g_blank
            // R2: erased terms stay low
            p_blank_term_r2: assert property (@(posedge clk) disable iff (rst)
                (term_map[t] == '0) |-> !pt_out[t]);
        end
    endgenerate

endmodule

// File: tb/pterm_alloc_core_test.sv
`timescale 1ns/1ps
module pterm_alloc_core_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [35:0]  in_sig = '0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [85:0]  cfg_wdata = '0;
    logic         cfg_err;
    logic [85:0]  pt_out;
    logic [255:0] sum_bundle;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pterm_alloc_core uut (
        .clk(clk), .rst(rst), .in_sig(in_sig), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .pt_out(pt_out), .sum_bundle(sum_bundle)
    );

    // behavioural reference state
    logic [71:0] m_term  [86];
    logic [85:0] m_steer [16];
    logic        m_err;

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < 86; t++) m_term[t] <= '0;
            for (int c = 0; c < 16; c++) m_steer[c] <= '0;
            m_err <= 1'b0;
        end else begin
            m_err <= 1'b0;
            if (cfg_we) begin
                if (!cfg_addr[7] && cfg_addr[6:0] < 86)
                    m_term[cfg_addr[6:0]] <= cfg_wdata[71:0];
                if (cfg_addr[7] && cfg_addr[6:0] < 16) begin
                    if ($countones(cfg_wdata) > 16) m_err <= 1'b1;
                    else m_steer[cfg_addr[6:0]] <= cfg_wdata;
                end
            end
        end
    end

    task automatic compare(input string tag);
        logic [85:0]  e_pt;
        logic [255:0] e_b;
        for (int t = 0; t < 86; t++) begin
            logic v;
            v = (m_term[t] != '0);
            for (int i = 0; i < 36; i++) begin
                if (m_term[t][2*i]   && !in_sig[i]) v = 1'b0;
                if (m_term[t][2*i+1] &&  in_sig[i]) v = 1'b0;
            end
            e_pt[t] = v;
        end
        e_b = '0;
        for (int c = 0; c < 16; c++) begin
            int k;
            k = 0;
            for (int t = 0; t < 86; t++)
                if (m_steer[c][t]) begin
                    if (k < 16) e_b[c*16+k] = e_pt[t];
                    k++;
                end
        end
        checks += 3;
        if (pt_out !== e_pt) begin
            fails++;
            $display("FAIL %s pt_out got %h exp %h", tag, pt_out, e_pt);
        end
        if (sum_bundle !== e_b) begin
            fails++;
            $display("FAIL %s sum_bundle got %h exp %h", tag, sum_bundle, e_b);
        end
        if (cfg_err !== m_err) begin
            fails++;
            $display("FAIL %s cfg_err got %b exp %b", tag, cfg_err, m_err);
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [85:0] d, input string tag);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        #1 compare({tag, " R3 pre-edge"});
        step(tag);
        cfg_we = 1'b0;
    endtask

    function automatic logic [85:0] bits_from(input int lo, input int n);
        logic [85:0] r;
        r = '0;
        for (int i = lo; i < lo + n; i++) r[i] = 1'b1;
        return r;
    endfunction

    initial begin
        step("R10"); step("R10");
        rst = 1'b0;
        in_sig = 36'hA5A5_A5A5_A;
        step("R2 R10");

        wr({1'b0, 7'd0},  86'h9, "R1 R3");               // in0 & ~in1
        wr({1'b0, 7'd1},  86'h6, "R1 R3");               // ~in0 & in1
        wr({1'b0, 7'd5},  86'h1 << 70, "R1 R3");         // in35
        wr({1'b0, 7'd85}, 86'h20 | (86'h3FFF << 72), "R3"); // ~in2, high bits ignored
        wr({1'b1, 7'd0},  (86'h1 << 85) | 86'h21, "R4 R5");
        wr({1'b1, 7'd3},  86'h20, "R6");
        wr({1'b1, 7'd7},  86'h21, "R6");
        wr({1'b1, 7'd15}, bits_from(0, 16), "R8");
        wr({1'b1, 7'd2},  bits_from(70, 16), "R8");
        wr({1'b1, 7'd1},  bits_from(0, 17), "R7");
        step("R7 flag clears");
        wr({1'b1, 7'd15}, bits_from(10, 20), "R7 keep");
        step("R7");
        wr({1'b1, 7'd20}, 86'h7, "R9");
        wr({1'b0, 7'd100}, 86'hF, "R9");
        wr({1'b0, 7'd127}, 86'h1, "R9");

        foreach (in_sig[i]) begin
            in_sig = 36'h0;
            in_sig[i] = 1'b1;
            #1 compare("R11 R1");
            step("R5 R6 R8");
        end
        in_sig = 36'h8_0000_0001;
        #1 compare("R11 R5");
        in_sig = 36'h8_0000_0002;
        #1 compare("R11 R1");

        for (int n = 0; n < 60; n++) begin
            logic [85:0] row;
            row = '0;
            if (n % 2 == 0) begin
                repeat ($urandom_range(1, 2)) row[$urandom_range(0, 71)] = 1'b1;
                wr({1'b0, 7'($urandom_range(0, 85))}, row, "R1 R3");
            end else begin
                repeat ($urandom_range(0, 22)) row[$urandom_range(0, 85)] = 1'b1;
                wr({1'b1, 7'($urandom_range(0, 15))}, row, "R4 R5 R7");
            end
            repeat (4) begin
                in_sig = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
                #1 compare("R11");
                step("R5 R6");
            end
        end

        rst = 1'b1;
        step("R10");
        rst = 1'b0;
        step("R10 R2");
        step("R8 empty");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule